// File: doc/BRIEF.md
# Prioritized External Interrupt Controller

This block gathers one non-maskable request, one level-sensitive request line and a parameterized set of edge-sensitive request lines. It decides which of them the CPU should service next. Each maskable line has its own enable bit and its own 3-bit priority register. A maskable request is only granted when its priority is strictly above the 3-bit mask level the block holds for the CPU. Edge requests that are blocked only by the mask stay pending until the mask drops. The level line is never held: it counts only while it is asserted.

Arbitration runs every cycle. Its result travels through a short snapshot pipeline, so the winner offered at the CPU's acceptance point is the one that was present a fixed number of cycles earlier. When the CPU accepts, the granted edge or non-maskable request is cleared. Once the CPU reports that the status word has been saved, the mask level takes the accepted request's level.

The vector index numbering is fixed:
- 0 is the non-maskable request.
- 1 is the level line (line 0).
- 2 + k is edge line k (line k + 1).

Top module: `irq_prio_ctrl`

## Requirements
- R1: Edge lines and the non-maskable input are sampled on the falling clock edge, and a 0-to-1 change between two successive samples is one event. The level line is sampled on the rising clock edge.
- R2: An edge event on a line whose enable bit is 0 is not captured, and setting that enable bit later never produces a request from the earlier event.
- R3: An enabled edge event is latched as pending. A pending line with priority not above the mask is not offered, but it becomes offered once the mask drops below its priority. Clearing its enable bit does not cancel it.
- R4: The level line is offered only while its sampled value is 1, its enable bit is 1 and its priority exceeds the mask. It is never latched.
- R5: On a cycle where `accept` is high and `irq_req` is high, the offered edge or non-maskable request is cleared and `irq_req` is low in the next cycle. An event seen in or after that cycle is latched again.
- R6: A pending non-maskable request beats all other requests, ignores the mask and the enables, is offered with vector 0 and level 7, and is offered again even when the mask is already 7.
- R7: The request offered in a cycle is the arbitration winner from SNAP_LAG (default 4) cycles earlier. A higher-priority request that arrives before that window wins over an earlier lower one.
- R8: Among maskable requests of equal priority, the lower line index wins. Line 0 is the level line with vector 1, and edge line k has vector k + 2.
- R9: The mask resets to 7. A `sr_saved` pulse loads the level of the last accepted request into the mask, and otherwise a `mask_wr` pulse loads `mask_din`.
- R10: All priority registers reset to 0, so no maskable line can be offered until a nonzero priority is written through `prio_wr`/`prio_sel`/`prio_din`.
- R11: A non-maskable request is not offered until the first `instr_done` pulse after reset. A request that was already active when reset was released is still latched and is offered after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_in | input | 1 | Non-maskable request, rising-transition sensed |
| lvl_irq_in | input | 1 | Level-sensitive request line (line 0) |
| edge_irq_in | input | NUM_EDGE | Edge-sensitive request lines (lines 1..NUM_EDGE) |
| line_en | input | NUM_EDGE+1 | Per-line enable, bit j for line j |
| prio_wr | input | 1 | Priority register write strobe |
| prio_sel | input | $clog2(NUM_EDGE+1) | Line whose priority is written |
| prio_din | input | 3 | Priority value to write |
| mask_wr | input | 1 | Direct mask write strobe |
| mask_din | input | 3 | Mask value to write |
| instr_done | input | 1 | Pulse when an instruction completes |
| accept | input | 1 | CPU takes the offered request this cycle |
| sr_saved | input | 1 | Status word has been stacked; apply new mask |
| irq_req | output | 1 | A request is offered |
| irq_vec | output | $clog2(NUM_EDGE+2) | Vector index of the offered request |
| irq_lvl | output | 3 | Mask level to apply for the offered request |
| cur_mask | output | 3 | Current mask level |

## Verification
The assertions take four things for granted about the inputs:
- `sr_saved` arrives at least one cycle after the `accept` it belongs to.
- `accept` is raised only for one cycle at a time.
- Every input changes once per cycle, well clear of the falling edge, so the falling-edge samplers see a single settled value.
- An edge pulse stays high for at least one full cycle.

The stimulus keeps within these limits. It drives every input one time unit after the rising edge and holds edge pulses for a whole cycle. It waits at least one cycle after each accept before pulsing `sr_saved`. The behavioural model is compared against the outputs in every cycle, whatever the phase of the test.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
   localparam int PRIO_W = 3;
   typedef logic [PRIO_W-1:0] prio_t;
   localparam prio_t TOP_LEVEL = '1;
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] line_in,
   input  logic [W-1:0] en,
   input  logic [W-1:0] clr,
   output logic [W-1:0] pend
);
   logic [W-1:0] samp_now;
   logic [W-1:0] samp_old;
   logic [W-1:0] rise;

   generate
      if (W < 1) begin : g_bad_w
         $error("irq_edge_latch: W must be at least 1");
      end
   endgenerate

   // falling-edge samplers
   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         samp_now <= '0;
         samp_old <= '0;
      end else begin
         samp_now <= line_in;
         samp_old <= samp_now;
      end
   end

   assign rise = samp_now & ~samp_old;

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend[i] <= 1'b0;
         else        pend[i] <= (pend[i] & ~clr[i]) | (rise[i] & en[i]);
      end

      // R2
      disabled_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!pend[i] && !en[i]) |=> !pend[i]);

      // R3
      pending_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pend[i] && !clr[i]) |=> pend[i]);
   end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_ctrl_pkg::*;
#(
   parameter int NUM_LINES = 5,
   parameter int VEC_W     = 3
) (
   input  logic                 nmi_ok,
   input  logic [NUM_LINES-1:0] req,
   input  prio_t                prio [NUM_LINES],
   input  prio_t                mask,
   output logic                 win_valid,
   output logic [VEC_W-1:0]     win_vec,
   output prio_t                win_lvl
);
   logic             found;
   logic [VEC_W-1:0] best_idx;
   prio_t            best_p;

   always_comb begin
      found    = 1'b0;
      best_idx = '0;
      best_p   = '0;
      // walk downwards so an equal priority at a lower index replaces the holder
      for (int j = NUM_LINES - 1; j >= 0; j--) begin
         if (req[j] && (prio[j] > mask) && (!found || prio[j] >= best_p)) begin
            found    = 1'b1;
            best_p   = prio[j];
            best_idx = VEC_W'(j);
         end
      end
      if (nmi_ok) begin
         win_valid = 1'b1;
         win_vec   = '0;
         win_lvl   = TOP_LEVEL;
      end else begin
         win_valid = found;
         win_vec   = best_idx + VEC_W'(1);
         win_lvl   = best_p;
      end
   end
endmodule

// File: rtl/irq_snap_pipe.sv
module irq_snap_pipe #(
   parameter int W     = 7,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("irq_snap_pipe: DEPTH must be at least 1");
      end

      if (DEPTH == 1) begin : g_single
         logic [W-1:0] st;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     st <= '0;
            else if (flush) st <= '0;
            else            st <= din;
         end
         assign dout = st;
      end else begin : g_chain
         logic [W-1:0] st [DEPTH];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) st[i] <= '0;
            end else if (flush) begin
               for (int i = 0; i < DEPTH; i++) st[i] <= '0;
            end else begin
               st[0] <= din;
               for (int i = 1; i < DEPTH; i++) st[i] <= st[i-1];
            end
         end
         assign dout = st[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
   import irq_ctrl_pkg::*;
#(
   parameter int NUM_EDGE = 4,
   parameter int SNAP_LAG = 4,
   localparam int NUM_LINES = NUM_EDGE + 1,
   localparam int SEL_W     = $clog2(NUM_LINES),
   localparam int VEC_W     = $clog2(NUM_LINES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 nmi_in,
   input  logic                 lvl_irq_in,
   input  logic [NUM_EDGE-1:0]  edge_irq_in,
   input  logic [NUM_LINES-1:0] line_en,
   input  logic                 prio_wr,
   input  logic [SEL_W-1:0]     prio_sel,
   input  logic [2:0]           prio_din,
   input  logic                 mask_wr,
   input  logic [2:0]           mask_din,
   input  logic                 instr_done,
   input  logic                 accept,
   input  logic                 sr_saved,
   output logic                 irq_req,
   output logic [VEC_W-1:0]     irq_vec,
   output logic [2:0]           irq_lvl,
   output logic [2:0]           cur_mask
);
   localparam int PIPE_W = 1 + VEC_W + PRIO_W;

   generate
      if (NUM_EDGE < 1 || NUM_EDGE > 30) begin : g_bad_edges
         $error("irq_prio_ctrl: NUM_EDGE out of range");
      end
      if (SNAP_LAG < 1) begin : g_bad_lag
         $error("irq_prio_ctrl: SNAP_LAG must be at least 1");
      end
   endgenerate

   prio_t                prio_q [NUM_LINES];
   prio_t                mask_q;
   prio_t                acc_lvl_q;
   logic                 started_q;
   logic                 lvl_q;
   logic [NUM_EDGE-1:0]  edge_pend;
   logic [NUM_EDGE-1:0]  edge_clr;
   logic                 nmi_pend;
   logic                 nmi_clr;
   logic [NUM_LINES-1:0] line_req;
   logic                 win_valid;
   logic [VEC_W-1:0]     win_vec;
   prio_t                win_lvl;
   logic [PIPE_W-1:0]    snap_in;
   logic [PIPE_W-1:0]    snap_out;
   logic                 snap_valid;
   logic [VEC_W-1:0]     snap_vec;
   prio_t                snap_lvl;
   logic                 take;

   // request capture
   irq_edge_latch #(.W(NUM_EDGE)) u_edges (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (edge_irq_in),
      .en      (line_en[NUM_LINES-1:1]),
      .clr     (edge_clr),
      .pend    (edge_pend)
   );

   irq_edge_latch #(.W(1)) u_nmi (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (nmi_in),
      .en      (1'b1),
      .clr     (nmi_clr),
      .pend    (nmi_pend)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl_irq_in;
   end

   assign line_req = {edge_pend, lvl_q & line_en[0]};

   // arbitration and snapshot window
   irq_arbiter #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W)) u_arb (
      .nmi_ok    (nmi_pend & started_q),
      .req       (line_req),
      .prio      (prio_q),
      .mask      (mask_q),
      .win_valid (win_valid),
      .win_vec   (win_vec),
      .win_lvl   (win_lvl)
   );

   assign snap_in = {win_valid, win_vec, win_lvl};

   irq_snap_pipe #(.W(PIPE_W), .DEPTH(SNAP_LAG)) u_snap (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (take),
      .din   (snap_in),
      .dout  (snap_out)
   );

   assign {snap_valid, snap_vec, snap_lvl} = snap_out;
   assign take    = accept & snap_valid;
   assign nmi_clr = take && (snap_vec == '0);

   for (genvar k = 0; k < NUM_EDGE; k++) begin : g_clr
      assign edge_clr[k] = take && (snap_vec == VEC_W'(k + 2));
   end

   // priority, mask and start state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int j = 0; j < NUM_LINES; j++) prio_q[j] <= '0;
      end else if (prio_wr) begin
         for (int j = 0; j < NUM_LINES; j++)
            if (prio_sel == SEL_W'(j)) prio_q[j] <= prio_din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q    <= TOP_LEVEL;
         acc_lvl_q <= TOP_LEVEL;
         started_q <= 1'b0;
      end else begin
         if (sr_saved)     mask_q <= acc_lvl_q;
         else if (mask_wr) mask_q <= mask_din;
         if (take)         acc_lvl_q <= snap_lvl;
         if (instr_done)   started_q <= 1'b1;
      end
   end

   assign irq_req  = snap_valid;
   assign irq_vec  = snap_vec;
   assign irq_lvl  = snap_lvl;
   assign cur_mask = mask_q;

   // R3
   masked_not_granted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && win_vec != '0) |-> (win_lvl > mask_q));

   // R5
   accept_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && irq_req) |=> !irq_req);

   // R11
   nmi_after_first_instr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !started_q |-> !(irq_req && irq_vec == '0));

   // R6
   nmi_top_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && irq_vec == '0) |-> (irq_lvl == TOP_LEVEL));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
   localparam int NE  = 4;
   localparam int NL  = NE + 1;
   localparam int LAG = 4;

   typedef struct {
      bit v;
      int vec;
      int lvl;
   } ent_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          nmi_in = 1'b0;
   logic          lvl_irq_in = 1'b0;
   logic [NE-1:0] edge_irq_in = '0;
   logic [NL-1:0] line_en = '0;
   logic          prio_wr = 1'b0;
   logic [2:0]    prio_sel = '0;
   logic [2:0]    prio_din = '0;
   logic          mask_wr = 1'b0;
   logic [2:0]    mask_din = '0;
   logic          instr_done = 1'b0;
   logic          accept = 1'b0;
   logic          sr_saved = 1'b0;
   logic          irq_req;
   logic [2:0]    irq_vec;
   logic [2:0]    irq_lvl;
   logic [2:0]    cur_mask;

   irq_prio_ctrl #(.NUM_EDGE(NE), .SNAP_LAG(LAG)) u_dut (
      .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .lvl_irq_in(lvl_irq_in),
      .edge_irq_in(edge_irq_in), .line_en(line_en), .prio_wr(prio_wr),
      .prio_sel(prio_sel), .prio_din(prio_din), .mask_wr(mask_wr),
      .mask_din(mask_din), .instr_done(instr_done), .accept(accept),
      .sr_saved(sr_saved), .irq_req(irq_req), .irq_vec(irq_vec),
      .irq_lvl(irq_lvl), .cur_mask(cur_mask)
   );

   always #5 clk = ~clk;

   int    n_tests = 0;
   int    n_fail  = 0;
   bit    done    = 0;
   string phase   = "R9 reset";

   // staged inputs (applied in the next tick)
   bit       s_rst = 0, s_nmi = 0, s_lvl = 0, s_pw = 0, s_mw = 0, s_id = 0, s_acc = 0, s_sr = 0;
   bit [NE-1:0] s_edge = '0;
   bit [NL-1:0] s_en = '0;
   int       s_sel = 0, s_pd = 0, s_md = 0;

   // model state
   int   m_prio [NL];
   int   m_mask, m_acc;
   bit   m_started, m_lvlq, m_nmip, m_nprev;
   bit   m_pend [NE];
   bit   m_eprev [NE];
   ent_t hq[$];

   task automatic model_reset();
      for (int j = 0; j < NL; j++) m_prio[j] = 0;
      m_mask = 7; m_acc = 7; m_started = 0; m_lvlq = 0; m_nmip = 0; m_nprev = 0;
      for (int k = 0; k < NE; k++) begin m_pend[k] = 0; m_eprev[k] = 0; end
      hq.delete();
      for (int i = 0; i < LAG; i++) hq.push_back('{0, 0, 0});
   endtask

   // state update at a rising edge, from the inputs held in the ending cycle
   task automatic model_update();
      ent_t w, head;
      bit   take, r;
      if (!rst_n) begin
         model_reset();
         return;
      end
      w = '{0, 0, 0};
      if (m_nmip && m_started) w = '{1, 0, 7};
      else begin
         for (int j = 0; j < NL; j++) begin
            r = (j == 0) ? (m_lvlq && line_en[0]) : m_pend[j-1];
            if (r && m_prio[j] > m_mask && (!w.v || m_prio[j] > w.lvl)) w = '{1, j + 1, m_prio[j]};
         end
      end
      head = hq[0];
      take = accept && head.v;
      for (int k = 0; k < NE; k++) begin
         if (take && head.vec == k + 2) m_pend[k] = 0;
         if (edge_irq_in[k] && !m_eprev[k] && line_en[k+1]) m_pend[k] = 1;
         m_eprev[k] = edge_irq_in[k];
      end
      if (take && head.vec == 0) m_nmip = 0;
      if (nmi_in && !m_nprev) m_nmip = 1;
      m_nprev = nmi_in;
      if (sr_saved) m_mask = m_acc;
      else if (mask_wr) m_mask = mask_din;
      if (take) m_acc = head.lvl;
      if (prio_wr && prio_sel < NL) m_prio[prio_sel] = prio_din;
      if (instr_done) m_started = 1;
      m_lvlq = lvl_irq_in;
      void'(hq.pop_front());
      hq.push_back(w);
      if (take) for (int i = 0; i < LAG; i++) hq[i] = '{0, 0, 0};
   endtask

   task automatic compare_model();
      ent_t e;
      bit   bad;
      e = hq[0];
      n_tests++;
      bad = (irq_req !== e.v) || (cur_mask !== 3'(m_mask)) ||
            (e.v && (irq_vec !== 3'(e.vec) || irq_lvl !== 3'(e.lvl)));
      if (bad) begin
         n_fail++;
         $display("FAIL %s model: req/vec/lvl/mask got %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                  phase, irq_req, irq_vec, irq_lvl, cur_mask, e.v, e.vec, e.lvl, m_mask);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      model_update();
      #1;
      rst_n = s_rst; nmi_in = s_nmi; lvl_irq_in = s_lvl; edge_irq_in = s_edge;
      line_en = s_en; prio_wr = s_pw; prio_sel = 3'(s_sel); prio_din = 3'(s_pd);
      mask_wr = s_mw; mask_din = 3'(s_md); instr_done = s_id; accept = s_acc; sr_saved = s_sr;
      s_pw = 0; s_mw = 0; s_id = 0; s_acc = 0; s_sr = 0;
      #7;
      compare_model();
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic check(input string rq, input bit req, input int vec, input int lvl, input int msk);
      bit bad;
      n_tests++;
      bad = (irq_req !== req) || (req && (irq_vec !== 3'(vec) || irq_lvl !== 3'(lvl))) ||
            (msk >= 0 && cur_mask !== 3'(msk));
      if (bad) begin
         n_fail++;
         $display("FAIL %s: req/vec/lvl/mask got %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                  rq, irq_req, irq_vec, irq_lvl, cur_mask, req, vec, lvl, msk);
      end
   endtask

   task automatic pulse_edges(input bit [NE-1:0] p);
      s_edge = p; tick(); s_edge = '0; tick();
   endtask

   task automatic set_mask(input int v);
      s_mw = 1; s_md = v; tick();
   endtask

   task automatic take_it();
      s_acc = 1; tick(); tick();
   endtask

   initial begin
      model_reset();
      // R9 R11: reset with non-maskable request already active
      s_nmi = 1;
      run(3);
      s_rst = 1;
      run(10);
      phase = "R11";
      check("R9 mask after reset", 0, 0, 0, 7);
      check("R11 no NMI before first instruction", 0, 0, 0, 7);
      s_id = 1; tick();
      run(LAG + 3);
      phase = "R6";
      check("R11 NMI after first instruction", 1, 0, 7, 7);
      take_it();
      check("R5 request drops after accept", 0, 0, 0, 7);
      s_sr = 1; tick(); tick();
      check("R9 mask after NMI save", 0, 0, 0, 7);
      s_nmi = 0; run(2); s_nmi = 1; run(LAG + 3);
      check("R6 NMI re-entry at mask 7", 1, 0, 7, 7);
      take_it(); s_sr = 1; tick(); s_nmi = 0; run(3);

      // R10: priorities still 0, level line cannot win
      phase = "R10";
      set_mask(0);
      s_en = 5'b00001; s_lvl = 1; run(LAG + 3);
      check("R10 zero priority never offered", 0, 0, 0, 0);
      s_lvl = 0; s_en = '0; run(2);
      begin
         int pv [NL] = '{2, 3, 5, 5, 1};
         for (int j = 0; j < NL; j++) begin
            s_pw = 1; s_sel = j; s_pd = pv[j]; tick();
         end
      end

      // R2: disabled line event is dropped
      phase = "R2";
      pulse_edges(4'b0010);
      run(2);
      s_en = 5'b00100; tick();
      run(LAG + 3);
      check("R2 disabled edge not captured", 0, 0, 0, 0);

      // R3: masked pending survives enable clear
      phase = "R3";
      set_mask(7);
      s_en = 5'b00010; tick();
      pulse_edges(4'b0001);
      run(2);
      s_en = '0; run(LAG + 3);
      check("R3 masked request not offered", 0, 0, 0, 7);
      set_mask(2);
      run(LAG + 3);
      check("R3 pending offered after mask drop", 1, 2, 3, 2);
      take_it();
      check("R5 cleared on accept", 0, 0, 0, 2);
      s_sr = 1; tick(); tick();
      check("R9 mask takes accepted level", 0, 0, 0, 3);

      // R5: relatch after accept
      phase = "R5";
      s_en = 5'b00010; set_mask(0);
      pulse_edges(4'b0001);
      run(LAG + 3);
      check("R5 new edge latched again", 1, 2, 3, 0);
      take_it(); run(LAG + 2);
      check("R5 no stale request", 0, 0, 0, 0);

      // R7: later higher priority wins after the window
      phase = "R7";
      s_en = 5'b00110; tick();
      pulse_edges(4'b0001);
      run(LAG + 3);
      check("R7 first request offered", 1, 2, 3, 0);
      s_edge = 4'b0010; tick(); s_edge = '0; tick();
      check("R7 window still shows older winner", 1, 2, 3, 0);
      run(LAG + 2);
      check("R7 higher priority wins", 1, 3, 5, 0);
      take_it(); run(LAG + 2);
      check("R7 lower request still pending", 1, 2, 3, 0);
      take_it(); run(LAG + 2);
      check("R7 all served", 0, 0, 0, 0);

      // R8: tie at priority 5, lower index first
      phase = "R8";
      s_en = 5'b01100; tick();
      pulse_edges(4'b0110);
      run(LAG + 3);
      check("R8 tie lower index", 1, 3, 5, 0);
      take_it(); run(LAG + 2);
      check("R8 tie second", 1, 4, 5, 0);
      take_it(); run(LAG + 2);

      // R4: level line
      phase = "R4";
      s_en = 5'b00001; s_lvl = 1; run(LAG + 3);
      check("R4 level offered", 1, 1, 2, 0);
      set_mask(2); run(LAG + 3);
      check("R4 level masked", 0, 0, 0, 2);
      s_lvl = 0; run(3); set_mask(0); run(LAG + 3);
      check("R4 level not held", 0, 0, 0, 0);

      // R1: event only on a 0-to-1 change; line held high gives one event
      phase = "R1";
      s_en = 5'b10000; s_edge = 4'b1000; run(3);
      run(LAG);
      check("R1 edge line 3 offered", 1, 5, 1, 0);
      take_it(); run(LAG + 2);
      check("R1 held-high line gives no second event", 0, 0, 0, 0);
      s_edge = '0; run(3);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule